// File: doc/BRIEF.md
# Dual-Sided Message Mailbox with Coupled Acknowledge

This block joins two agents, called side A (the function side) and side B (the host side). Each agent has its own simple register port. Each agent also has its own level interrupt. In each direction a sender fills four 32-bit transmit words. Word 0 holds a request or event code and words 1 to 3 hold parameters. The receiver sees those four words through its own read-only receive window.

A sender raises a message-valid flag. The receiver answers by writing an acknowledge code into its receive control byte. The acknowledge shows up at the sender as a read-only transmit-ack flag. When the sender drops its valid flag, the hardware clears the acknowledge state on both sides in the same cycle. A sender polling for the ack of its next message therefore never sees the ack left over from the previous message.

Interrupt generation is part of the block. An agent can enable a "message received" interrupt, an "acknowledge received" interrupt, or both. Message meaning, timeouts and retries are left to software.

Top module: `dual_mailbox`

Word offsets are identical on both sides (default of four words per message): 0..3 transmit words, 4..7 receive words, 8 transmit control, 9 receive control, 10 interrupt enables. Unmapped offsets read zero.

## Requirements
- R1: After reset, every register on both sides reads zero: transmit words, receive words, both control bytes and the interrupt enables. Both interrupt outputs are low.
- R2: A word written at offsets 0..3 reads back at the same offset on the writing side. It also reads at offset 4 + n on the peer side; word 0 appears at peer offset 4. Both reads are visible one cycle after the write.
- R3: Writing the transmit control byte (offset 8) sets the valid flag when bit 0 is 1 and clears it when bit 0 is 0. The writer reads the flag in bit 0 of offset 8. The peer reads it as receive-valid in bit 0 of offset 9.
- R4: The receiver writes exactly 8'h02 to its receive control byte (offset 9) while a message is valid. The ack flag is then set. The sender reads it in bit 1 of offset 8, and the receiver reads it in bit 1 of offset 9.
- R5: Other values written to offset 9 are ignored. A 8'h02 written while no message is valid is also ignored. Neither produces an ack at the sender, including after a later send.
- R6: Clearing the sender's valid flag clears the ack on both sides in the same clock edge. The next send starts with transmit-ack at 0.
- R7: Bit 1 of the transmit control byte is read-only. Writing 8'h03 while valid is set leaves valid at 1 and ack at 0.
- R8: The interrupt enable register (offset 10) has two bits that are read and written independently. Bit 0 enables the message-received interrupt and bit 1 enables the ack-received interrupt.
- R9: Message-received is pending from the rising edge of receive-valid until the receiver acknowledges or the sender withdraws the message. While it is pending and enabled, the receiver's interrupt is high.
- R10: Ack-received is pending while the sender's transmit-ack is set, and it clears when the sender clears valid. While it is pending and enabled, the sender's interrupt is high.
- R11: The two directions are independent. Handshake activity in one direction leaves the other direction's valid and ack flags unchanged.
- R12: Writes to the receive words (offsets 4..7) have no effect. Offsets 11 and above read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wen | input | 1 | Side A write strobe |
| a_addr | input | AW (4) | Side A word offset |
| a_wdata | input | DW (32) | Side A write data |
| a_rdata | output | DW (32) | Side A read data, combinational from a_addr |
| a_irq | output | 1 | Side A level interrupt |
| b_wen | input | 1 | Side B write strobe |
| b_addr | input | AW (4) | Side B word offset |
| b_wdata | input | DW (32) | Side B write data |
| b_rdata | output | DW (32) | Side B read data, combinational from b_addr |
| b_irq | output | 1 | Side B level interrupt |

## Verification
The hardest case to reach is the stale acknowledge. A message must be acknowledged, then withdrawn. A new message must then be raised and transmit-ack must be seen to start at zero. In between, a stray ack code is written while no message is valid. The directed sequence reaches this by chaining these steps: an acknowledged A-to-B handshake, a withdrawal, a stray ack write, and a fresh send. Each step reads both control bytes. A second sequence runs both directions at once, so that an ack in one direction is checked against the other direction's flags.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Handshake state of one direction (sender -> receiver).
    typedef struct packed {
        logic valid;  // sender's message-valid flag
        logic ack;    // receiver's acknowledge, mirrored as sender's transmit-ack
        logic pend;   // receiver's message-received event pending
    } link_t;

    localparam logic [7:0] ACK_CODE = 8'h02;

endpackage

// File: rtl/mbx_link.sv
module mbx_link
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vld_we,    // sender writes its transmit control byte
    input  logic vld_val,   // bit 0 of that write
    input  logic ack_req,   // receiver wrote the ack code
    output logic valid,
    output logic ack,
    output logic pend
);

    link_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (vld_we) begin
            st_d.valid = vld_val;
        end
        if (!st_d.valid) begin
            // Withdrawal clears both the receiver's ack and the mirrored transmit-ack.
            st_d.ack  = 1'b0;
            st_d.pend = 1'b0;
        end else begin
            if (ack_req && st_q.valid) begin
                st_d.ack = 1'b1;
            end
            if (!st_q.valid) begin
                st_d.pend = 1'b1;
            end else if (st_d.ack) begin
                st_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid = st_q.valid;
    assign ack   = st_q.ack;
    assign pend  = st_q.pend;

endmodule

// File: rtl/mbx_port.sv
module mbx_port
    import mbx_pkg::*;
#(
    parameter int NW = 4,
    parameter int DW = 32,
    parameter int AW = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wen,
    input  logic [AW-1:0]          addr,
    input  logic [DW-1:0]          wdata,
    output logic [DW-1:0]          rdata,
    output logic                   irq,
    output logic [NW-1:0][DW-1:0]  tx_words,
    input  logic [NW-1:0][DW-1:0]  rx_words,
    input  logic                   tx_valid,
    input  logic                   tx_ack,
    input  logic                   rx_valid,
    input  logic                   rx_ack,
    input  logic                   rx_pend,
    output logic                   vld_we,
    output logic                   vld_val,
    output logic                   ack_req
);

    localparam int IW = (NW > 1) ? $clog2(NW) : 1;
    localparam logic [AW-1:0] OFF_RX  = AW'(NW);
    localparam logic [AW-1:0] OFF_TXC = AW'(2 * NW);
    localparam logic [AW-1:0] OFF_RXC = AW'(2 * NW + 1);
    localparam logic [AW-1:0] OFF_IEN = AW'(2 * NW + 2);

    typedef struct packed {
        logic [NW-1:0][DW-1:0] tx;
        logic [1:0]            ien;
    } port_st_t;

    port_st_t st_d, st_q;
    logic [AW-1:0] roff;

    assign roff = addr - OFF_RX;

    always_comb begin
        st_d    = st_q;
        vld_we  = 1'b0;
        vld_val = 1'b0;
        ack_req = 1'b0;
        if (wen) begin
            if (addr < OFF_RX) begin
                st_d.tx[addr[IW-1:0]] = wdata;
            end else if (addr == OFF_TXC) begin
                vld_we  = 1'b1;
                vld_val = wdata[0];
            end else if (addr == OFF_RXC) begin
                ack_req = (wdata[7:0] == ACK_CODE);
            end else if (addr == OFF_IEN) begin
                st_d.ien = wdata[1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr < OFF_RX) begin
            rdata = st_q.tx[addr[IW-1:0]];
        end else if (addr < OFF_TXC) begin
            rdata = rx_words[roff[IW-1:0]];
        end else if (addr == OFF_TXC) begin
            rdata[1:0] = {tx_ack, tx_valid};
        end else if (addr == OFF_RXC) begin
            rdata[1:0] = {rx_ack, rx_valid};
        end else if (addr == OFF_IEN) begin
            rdata[1:0] = st_q.ien;
        end
    end

    assign tx_words = st_q.tx;
    assign irq      = (st_q.ien[0] & rx_pend) | (st_q.ien[1] & tx_ack);

endmodule

// File: rtl/dual_mailbox.sv
module dual_mailbox
    import mbx_pkg::*;
#(
    parameter int NW = 4,
    parameter int DW = 32,
    localparam int AW = $clog2(2 * NW + 3)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_wen,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    output logic          a_irq,
    input  logic          b_wen,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_irq
);

    // Index 0 = side A, index 1 = side B. Link d carries side d's message to side 1-d.
    logic [1:0]                    s_wen;
    logic [1:0][AW-1:0]            s_addr;
    logic [1:0][DW-1:0]            s_wdata;
    logic [1:0][DW-1:0]            s_rdata;
    logic [1:0]                    s_irq;
    logic [1:0][NW-1:0][DW-1:0]    txw;
    logic [1:0]                    vld_we, vld_val, ack_req;
    logic [1:0]                    lk_valid, lk_ack, lk_pend;

    assign s_wen   = {b_wen, a_wen};
    assign s_addr  = {b_addr, a_addr};
    assign s_wdata = {b_wdata, a_wdata};
    assign a_rdata = s_rdata[0];
    assign b_rdata = s_rdata[1];
    assign a_irq   = s_irq[0];
    assign b_irq   = s_irq[1];

    for (genvar s = 0; s < 2; s++) begin : g_side
        localparam int P = 1 - s;

        mbx_port #(.NW(NW), .DW(DW), .AW(AW)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .wen      (s_wen[s]),
            .addr     (s_addr[s]),
            .wdata    (s_wdata[s]),
            .rdata    (s_rdata[s]),
            .irq      (s_irq[s]),
            .tx_words (txw[s]),
            .rx_words (txw[P]),
            .tx_valid (lk_valid[s]),
            .tx_ack   (lk_ack[s]),
            .rx_valid (lk_valid[P]),
            .rx_ack   (lk_ack[P]),
            .rx_pend  (lk_pend[P]),
            .vld_we   (vld_we[s]),
            .vld_val  (vld_val[s]),
            .ack_req  (ack_req[s])
        );

        mbx_link u_link (
            .clk     (clk),
            .rst_n   (rst_n),
            .vld_we  (vld_we[s]),
            .vld_val (vld_val[s]),
            .ack_req (ack_req[P]),
            .valid   (lk_valid[s]),
            .ack     (lk_ack[s]),
            .pend    (lk_pend[s])
        );
    end

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] valid,
    input logic [1:0] ack,
    input logic [1:0] pend,
    input logic       a_irq,
    input logic       b_irq
);

    // R1: reset leaves every handshake flag clear
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (valid == 2'b00 && ack == 2'b00 && pend == 2'b00));

    // R6: an ack never outlives its message
    a_r6_ack_needs_valid_0: assert property (@(posedge clk) disable iff (!rst_n)
        ack[0] |-> valid[0]);
    a_r6_ack_needs_valid_1: assert property (@(posedge clk) disable iff (!rst_n)
        ack[1] |-> valid[1]);

    // R5: an ack only appears for a message that was already valid
    a_r5_ack_on_live_msg_0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack[0]) |-> $past(valid[0]));
    a_r5_ack_on_live_msg_1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack[1]) |-> $past(valid[1]));

    // R9: message-received becomes pending only on a rising receive-valid
    a_r9_pend_on_edge_0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[0]) |-> $rose(valid[0]));
    a_r9_pend_on_edge_1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[1]) |-> $rose(valid[1]));

    // R10: an interrupt always has a pending source behind it
    a_r10_irq_source_a: assert property (@(posedge clk) disable iff (!rst_n)
        a_irq |-> (pend[1] || ack[0]));
    a_r10_irq_source_b: assert property (@(posedge clk) disable iff (!rst_n)
        b_irq |-> (pend[0] || ack[1]));

endmodule

bind dual_mailbox mbx_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (lk_valid),
    .ack   (lk_ack),
    .pend  (lk_pend),
    .a_irq (a_irq),
    .b_irq (b_irq)
);

// File: tb/tb_dual_mailbox.sv
module tb_dual_mailbox;
    timeunit 1ns;
    timeprecision 1ps;

    localparam bit SA = 1'b0;
    localparam bit SB = 1'b1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_wen = 1'b0, b_wen = 1'b0;
    logic [3:0]  a_addr = '0, b_addr = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    dual_mailbox dut (
        .clk(clk), .rst_n(rst_n),
        .a_wen(a_wen), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq(a_irq),
        .b_wen(b_wen), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input bit s, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        if (s == SA) begin a_wen = 1'b1; a_addr = a; a_wdata = d; end
        else         begin b_wen = 1'b1; b_addr = a; b_wdata = d; end
        @(negedge clk);
        a_wen = 1'b0;
        b_wen = 1'b0;
    endtask

    task automatic rd(input bit s, input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        if (s == SA) a_addr = a; else b_addr = a;
        #1;
        d = (s == SA) ? a_rdata : b_rdata;
    endtask

    task automatic chk_rd(input string req, input bit s, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(s, a, v);
        check(req, v, exp);
    endtask

    task automatic chk_irq(input string req, input logic ea, input logic eb);
        @(negedge clk);
        #1;
        check({req, " a_irq"}, {31'b0, a_irq}, {31'b0, ea});
        check({req, " b_irq"}, {31'b0, b_irq}, {31'b0, eb});
    endtask

    task automatic t_reset();
        for (int i = 0; i < 11; i++) begin
            chk_rd("R1 side A reset", SA, 4'(i), 32'h0);
            chk_rd("R1 side B reset", SB, 4'(i), 32'h0);
        end
        chk_irq("R1 reset irq", 1'b0, 1'b0);
    endtask

    task automatic t_data();
        for (int i = 0; i < 4; i++) wr(SA, 4'(i), 32'hA000_0000 + 32'(i * 17));
        for (int i = 0; i < 4; i++) begin
            chk_rd("R2 own readback", SA, 4'(i), 32'hA000_0000 + 32'(i * 17));
            chk_rd("R2 peer view", SB, 4'(4 + i), 32'hA000_0000 + 32'(i * 17));
        end
        wr(SB, 4'd5, 32'hDEAD_BEEF);
        chk_rd("R12 rx word write ignored", SB, 4'd5, 32'hA000_0011);
        chk_rd("R12 peer tx unchanged", SA, 4'd1, 32'hA000_0011);
        chk_rd("R12 unmapped zero", SA, 4'd11, 32'h0);
        chk_rd("R12 unmapped zero top", SB, 4'd15, 32'h0);
    endtask

    task automatic t_ien();
        wr(SA, 4'd10, 32'h1);
        chk_rd("R8 enable bit0 only", SA, 4'd10, 32'h1);
        wr(SA, 4'd10, 32'h3);
        chk_rd("R8 both enables", SA, 4'd10, 32'h3);
        wr(SA, 4'd10, 32'hFFFF_FFFE);
        chk_rd("R8 bit1 alone", SA, 4'd10, 32'h2);
        wr(SB, 4'd10, 32'h1);
        chk_rd("R8 side B enable", SB, 4'd10, 32'h1);
        chk_rd("R8 side A untouched", SA, 4'd10, 32'h2);
    endtask

    // A (ack irq enabled) sends to B (rcv irq enabled)
    task automatic t_handshake();
        wr(SA, 4'd8, 32'h1);
        chk_rd("R3 sender valid", SA, 4'd8, 32'h1);
        chk_rd("R3 receiver valid", SB, 4'd9, 32'h1);
        chk_irq("R9 rcv irq raised", 1'b0, 1'b1);
        wr(SA, 4'd8, 32'h3);
        chk_rd("R7 ack bit read-only", SA, 4'd8, 32'h1);
        wr(SB, 4'd9, 32'h3);
        chk_rd("R5 wrong ack code ignored", SA, 4'd8, 32'h1);
        wr(SB, 4'd9, 32'h2);
        chk_rd("R4 sender sees ack", SA, 4'd8, 32'h3);
        chk_rd("R4 receiver sees ack", SB, 4'd9, 32'h3);
        chk_irq("R9/R10 after ack", 1'b1, 1'b0);
        wr(SA, 4'd8, 32'h0);
        chk_rd("R6 sender ack cleared", SA, 4'd8, 32'h0);
        chk_rd("R6 receiver ack cleared", SB, 4'd9, 32'h0);
        chk_irq("R10 ack irq cleared", 1'b0, 1'b0);
    endtask

    task automatic t_stale();
        wr(SB, 4'd9, 32'h2);
        chk_rd("R5 ack without message ignored", SA, 4'd8, 32'h0);
        wr(SA, 4'd8, 32'h1);
        chk_rd("R6 fresh send no stale ack", SA, 4'd8, 32'h1);
        chk_irq("R9 rcv irq on new msg", 1'b0, 1'b1);
        wr(SA, 4'd8, 32'h0);
        chk_irq("R9 withdraw clears rcv irq", 1'b0, 1'b0);
        chk_rd("R3 valid cleared at receiver", SB, 4'd9, 32'h0);
    endtask

    task automatic t_both();
        wr(SB, 4'd0, 32'h0000_00C5);
        chk_rd("R2 B to A word0", SA, 4'd4, 32'h0000_00C5);
        wr(SA, 4'd8, 32'h1);
        wr(SB, 4'd8, 32'h1);
        wr(SA, 4'd9, 32'h2);
        chk_rd("R11 B tx acked", SB, 4'd8, 32'h3);
        chk_rd("R11 A tx not acked", SA, 4'd8, 32'h1);
        chk_rd("R11 B rx view", SB, 4'd9, 32'h1);
        wr(SB, 4'd8, 32'h0);
        chk_rd("R11 A tx still valid", SA, 4'd8, 32'h1);
        chk_rd("R6 A rx cleared", SA, 4'd9, 32'h0);
        wr(SB, 4'd9, 32'h2);
        chk_rd("R4 A tx acked", SA, 4'd8, 32'h3);
        chk_rd("R11 B tx idle", SB, 4'd8, 32'h0);
        wr(SA, 4'd8, 32'h0);
        chk_rd("R6 final clear", SB, 4'd9, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_data();
        t_ien();
        t_handshake();
        t_stale();
        t_both();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule